// File: doc/BRIEF.md
# DMA Channel Control Registers with Interrupt Gating

This block is the software-visible front end of a simple bus-master DMA channel. It holds four 32-bit words behind a small memory-mapped window: a control/status word, a transfer address pointer, a byte count and an address-extension word. Reads are combinational from the selected word. Writes take effect at the next clock edge. The memory datapath lives elsewhere. It reports each finished transfer to this block as a one-cycle done strobe carrying a byte length, and the block adds that length to the address pointer.

The control word gates a level interrupt from the attached peripheral. An edge on the peripheral's request line sets or clears a pending flag, and the interrupt output follows that flag only while the enable bit is set. The control word also drives two signals toward the peripheral: a level enable taken from the DMA-enable bit, and a one-cycle reset pulse raised by writing the reset bit. Some control bits are read-only: a version field, the pending flag and the address-loaded flag. Several bits have write side effects: writing zero requests a FIFO drain, and writing the address word marks the address as loaded.

A static mode input selects the wider window used by the network flavour of the channel. In that mode, offsets beyond the window read as zero and ignore writes.

Top module: `dma_csr_unit`

## Requirements
- R1: The word is selected by address bits [3:2] (0 control, 1 address, 2 count, 3 extension). Offsets 0x10 to 0x1F alias onto the same four words. Accesses whose address bits [1:0] are not zero are ignored: a read returns 0 and a write changes nothing.
- R2: Control word fields: bit 0 pending interrupt, bit 4 interrupt enable, bit 6 drain request, bit 7 peripheral reset request, bit 8 toward-memory direction, bit 9 DMA enable, bit 26 address loaded.
- R3: A control write cannot change the bits under mask 0xFE000007. The value 0xA0000000 is ORed into the stored word on every control write, and the other bits under the mask keep their previous values.
- R4: After reset the control word reads 0xA0000000, the other three words read 0, and irq_out, dev_enable and dev_reset_pulse are all 0.
- R5: A rising edge on dev_irq sets the pending bit, and irq_out asserts only if the interrupt-enable bit is set. A falling edge while the bit is pending clears it and deasserts irq_out.
- R6: A control write with bit 4 set while the pending bit is set asserts irq_out. A control write with bit 4 clear deasserts irq_out.
- R7: A control write with bit 7 set produces dev_reset_pulse high for exactly the following cycle. If bit 7 is clear, a write with bit 6 set stores bit 6 as 0, and a write of all zeros stores bit 6 as 1.
- R8: dev_enable equals the stored DMA-enable bit (bit 9) and changes in the cycle after the control write.
- R9: Writing the address word also sets control bit 26.
- R10: With wide_mode high the window spans 32 bytes. Reads at offsets 0x20 and above return 0, and writes there change no word. In both modes, offsets 0x10 to 0x1F map onto the four words.
- R11: Each done strobe adds xfer_len to the address word. A software write to the address word in the same cycle wins over the increment.
- R12: irq_out is registered: it changes in the clock cycle after the input edge or control write that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | Selects the 32-byte network window |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| dev_irq | input | 1 | Peripheral interrupt request level |
| xfer_done | input | 1 | One-cycle transfer completion strobe |
| xfer_len | input | 16 | Bytes moved by the completed transfer |
| irq_out | output | 1 | Gated interrupt level |
| dev_enable | output | 1 | DMA enable level to the peripheral |
| dev_reset_pulse | output | 1 | One-cycle reset to the peripheral |

## Verification
The hardest state to reach from the ports is an interrupt that is pending but masked, followed by a control write that unmasks it. This must raise irq_out with no new edge on dev_irq. The bench reaches this state by raising dev_irq with the enable bit clear, then reading the control word back to confirm the pending bit. Only then does it write the enable bit, and it checks irq_out one cycle later. The pointer priority case needs a done strobe and an address write in the same clock. The bench drives both from one task at a single falling edge.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int unsigned CSR_W   = 32;
  localparam int unsigned N_WORDS = 4;

  localparam logic [CSR_W-1:0] RO_MASK   = 32'hFE00_0007;
  localparam logic [CSR_W-1:0] VER_FIELD = 32'hA000_0000;

  localparam int unsigned B_PEND   = 0;
  localparam int unsigned B_IEN    = 4;
  localparam int unsigned B_DRAIN  = 6;
  localparam int unsigned B_PRST   = 7;
  localparam int unsigned B_TOMEM  = 8;
  localparam int unsigned B_DEN    = 9;
  localparam int unsigned B_LOADED = 26;

  typedef enum logic [1:0] {
    WSEL_CTRL = 2'd0,
    WSEL_ADDR = 2'd1,
    WSEL_CNT  = 2'd2,
    WSEL_EXT  = 2'd3
  } wsel_e;

endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
  import dma_csr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned NARROW_SPAN = 16,
  parameter int unsigned WIDE_SPAN   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wide_mode,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  output wsel_e              word_sel,
  output logic               rd_hit,
  output logic [N_WORDS-1:0] wr_vec
);

  localparam int unsigned IDX_LO = 2;
  localparam int unsigned IDX_W  = $clog2(N_WORDS);
  localparam logic [ADDR_W-1:0] WIDE_LIMIT = ADDR_W'(WIDE_SPAN);
  localparam logic [ADDR_W-1:0] NARROW_MSK = ADDR_W'(NARROW_SPAN - 1);

  logic [ADDR_W-1:0] off_masked;
  logic              aligned;
  logic              in_window;
  logic              hit;

  always_comb begin
    off_masked = bus_addr & NARROW_MSK;
    aligned    = (bus_addr[IDX_LO-1:0] == '0);
    in_window  = wide_mode ? (bus_addr < WIDE_LIMIT) : 1'b1;
    hit        = bus_sel && aligned && in_window;
    word_sel   = wsel_e'(off_masked[IDX_LO +: IDX_W]);
    rd_hit     = hit && !bus_wr;
  end

  for (genvar g = 0; g < N_WORDS; g++) begin : g_we
    assign wr_vec[g] = hit && bus_wr && (off_masked[IDX_LO +: IDX_W] == IDX_W'(g));
  end

  // R10: no word strobe outside the wide window
  p_wide_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode && bus_addr >= WIDE_LIMIT) |-> (wr_vec == '0 && !rd_hit));

  // R1: at most one word written per access
  p_onehot_we_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));

endmodule

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [CSR_W-1:0] wdata,
  input  logic             loaded_set,
  input  logic             dev_irq,
  output logic [CSR_W-1:0] ctrl_q,
  output logic             irq_out,
  output logic             dev_enable,
  output logic             dev_reset_pulse
);

  logic [CSR_W-1:0] ctrl_d;
  logic [CSR_W-1:0] merged;
  logic             irq_q, irq_d;
  logic             pulse_q, pulse_d;
  logic             req_prev_q;
  logic             req_rise, req_fall;
  logic             ctrl_en;

  always_comb begin
    req_rise = dev_irq && !req_prev_q;
    req_fall = !dev_irq && req_prev_q;
    ctrl_en  = ctrl_we || loaded_set || req_rise || req_fall;

    merged  = wdata;
    pulse_d = 1'b0;
    ctrl_d  = ctrl_q;
    irq_d   = irq_q;

    if (ctrl_we) begin
      if (wdata[B_PRST]) begin
        pulse_d = 1'b1;
      end else if (wdata[B_DRAIN]) begin
        merged[B_DRAIN] = 1'b0;
      end else if (wdata == '0) begin
        merged[B_DRAIN] = 1'b1;
      end
      ctrl_d = (ctrl_q & RO_MASK) | (merged & ~RO_MASK) | VER_FIELD;
      irq_d  = wdata[B_IEN] ? (irq_q || ctrl_q[B_PEND]) : 1'b0;
    end

    if (loaded_set) begin
      ctrl_d[B_LOADED] = 1'b1;
    end

    if (req_rise) begin
      ctrl_d[B_PEND] = 1'b1;
      if (ctrl_d[B_IEN]) irq_d = 1'b1;
    end else if (req_fall && ctrl_q[B_PEND]) begin
      ctrl_d[B_PEND] = 1'b0;
      if (ctrl_d[B_IEN]) irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= VER_FIELD;
      irq_q      <= 1'b0;
      pulse_q    <= 1'b0;
      req_prev_q <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      irq_q      <= irq_d;
      pulse_q    <= pulse_d;
      req_prev_q <= dev_irq;
    end
  end

  assign irq_out         = irq_q;
  assign dev_enable      = ctrl_q[B_DEN];
  assign dev_reset_pulse = pulse_q;

  // R3: protected low bits survive a control write
  p_ro_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !dev_irq && !req_prev_q) |=> (ctrl_q[2:1] == $past(ctrl_q[2:1])));

  // R5: an asserted interrupt implies enabled and pending
  p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (ctrl_q[B_IEN] && ctrl_q[B_PEND]));

  // R6: writing the enable bit as zero drops the interrupt
  p_irq_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !wdata[B_IEN]) |=> !irq_out);

  // R7: reset request yields a pulse the next cycle, nothing else does
  p_pulse_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && wdata[B_PRST]) |=> dev_reset_pulse);
  p_pulse_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_we && wdata[B_PRST]) |=> !dev_reset_pulse);

  // R9: address write marks the address loaded
  p_loaded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_set |=> ctrl_q[B_LOADED]);

endmodule

// File: rtl/dma_csr_words.sv
module dma_csr_words #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic              cnt_we,
  input  logic              ext_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              xfer_done,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] ext_q
);

  localparam int unsigned N_PLAIN = 2;

  logic [DATA_W-1:0] addr_d;
  logic              addr_en;
  logic [N_PLAIN-1:0] plain_we;
  logic [DATA_W-1:0]  plain_q [N_PLAIN];

  always_comb begin
    addr_en = addr_we || xfer_done;
    addr_d  = addr_we ? wdata : (addr_q + DATA_W'(xfer_len));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign plain_we = {ext_we, cnt_we};

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        plain_q[g] <= '0;
      end else if (plain_we[g]) begin
        plain_q[g] <= wdata;
      end
    end
  end

  assign cnt_q = plain_q[0];
  assign ext_q = plain_q[1];

  // R11: done strobe advances the pointer by the length
  p_ptr_adv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !addr_we) |=> (addr_q == $past(addr_q) + DATA_W'($past(xfer_len))));

  // R11: software write wins over the increment
  p_ptr_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> (addr_q == $past(wdata)));

endmodule

// File: rtl/dma_csr_unit.sv
module dma_csr_unit
  import dma_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CSR_W-1:0]  bus_wdata,
  output logic [CSR_W-1:0]  bus_rdata,
  input  logic              dev_irq,
  input  logic              xfer_done,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              irq_out,
  output logic              dev_enable,
  output logic              dev_reset_pulse
);

  wsel_e              word_sel;
  logic               rd_hit;
  logic [N_WORDS-1:0] wr_vec;
  logic [CSR_W-1:0]   ctrl_q, addr_q, cnt_q, ext_q;

  dma_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide_mode (wide_mode),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .word_sel  (word_sel),
    .rd_hit    (rd_hit),
    .wr_vec    (wr_vec)
  );

  dma_csr_ctrl u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .ctrl_we         (wr_vec[WSEL_CTRL]),
    .wdata           (bus_wdata),
    .loaded_set      (wr_vec[WSEL_ADDR]),
    .dev_irq         (dev_irq),
    .ctrl_q          (ctrl_q),
    .irq_out         (irq_out),
    .dev_enable      (dev_enable),
    .dev_reset_pulse (dev_reset_pulse)
  );

  dma_csr_words #(.DATA_W(CSR_W), .LEN_W(LEN_W)) u_words (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_we   (wr_vec[WSEL_ADDR]),
    .cnt_we    (wr_vec[WSEL_CNT]),
    .ext_we    (wr_vec[WSEL_EXT]),
    .wdata     (bus_wdata),
    .xfer_done (xfer_done),
    .xfer_len  (xfer_len),
    .addr_q    (addr_q),
    .cnt_q     (cnt_q),
    .ext_q     (ext_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      unique case (word_sel)
        WSEL_CTRL: bus_rdata = ctrl_q;
        WSEL_ADDR: bus_rdata = addr_q;
        WSEL_CNT:  bus_rdata = cnt_q;
        WSEL_EXT:  bus_rdata = ext_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R8: peripheral enable tracks the DMA-enable bit of the control word
  p_enable_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vec[WSEL_CTRL]) |=> (dev_enable == $past(bus_wdata[B_DEN])));

endmodule

// File: tb/test_dma_csr_unit.sv
module test_dma_csr_unit;

  logic        clk;
  logic        rst_n;
  logic        wide_mode;
  logic        bus_sel;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        dev_irq;
  logic        xfer_done;
  logic [15:0] xfer_len;
  logic        irq_out;
  logic        dev_enable;
  logic        dev_reset_pulse;

  int total = 0;
  int bad   = 0;
  bit done_flag = 0;

  dma_csr_unit i_dma_csr_unit (
    .clk             (clk),
    .rst_n           (rst_n),
    .wide_mode       (wide_mode),
    .bus_sel         (bus_sel),
    .bus_wr          (bus_wr),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .dev_irq         (dev_irq),
    .xfer_done       (xfer_done),
    .xfer_len        (xfer_len),
    .irq_out         (irq_out),
    .dev_enable      (dev_enable),
    .dev_reset_pulse (dev_reset_pulse)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [5:0]  addr;
    logic [31:0] val;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'h08, 32'h1234_5678},  // R1 count word
    '{1'b0, 6'h08, 32'h1234_5678},
    '{1'b1, 6'h0C, 32'hDEAD_0000},  // R1 extension word
    '{1'b0, 6'h0C, 32'hDEAD_0000},
    '{1'b1, 6'h00, 32'h0000_0000},  // R7 zero write sets drain
    '{1'b0, 6'h00, 32'hA000_0040},
    '{1'b1, 6'h00, 32'h0000_0040},  // R7 drain written is cleared
    '{1'b0, 6'h00, 32'hA000_0000},
    '{1'b1, 6'h00, 32'h5FFF_FF3F},  // R3 protected bits and version
    '{1'b0, 6'h00, 32'hA1FF_FF38},
    '{1'b1, 6'h00, 32'h0000_0100},  // R2 direction bit stored
    '{1'b0, 6'h00, 32'hA000_0100},
    '{1'b1, 6'h04, 32'h0000_1000},  // R9 address write
    '{1'b0, 6'h04, 32'h0000_1000},
    '{1'b0, 6'h00, 32'hA400_0100},  // R9 loaded bit 26
    '{1'b0, 6'h14, 32'h0000_1000},  // R1 alias above 0x10
    '{1'b0, 6'h1C, 32'hDEAD_0000},
    '{1'b1, 6'h09, 32'hFFFF_FFFF},  // R1 misaligned write ignored
    '{1'b0, 6'h08, 32'h1234_5678}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; wide_mode = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; dev_irq = 1'b0; xfer_done = 1'b0; xfer_len = '0;
    repeat (3) @(negedge clk);
    check("R4 irq_out in reset", {31'd0, irq_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state
    bus_read(6'h00, rd); check("R4 control", rd, 32'hA000_0000);
    bus_read(6'h04, rd); check("R4 address", rd, 32'd0);
    bus_read(6'h08, rd); check("R4 count", rd, 32'd0);
    bus_read(6'h0C, rd); check("R4 extension", rd, 32'd0);
    check("R4 dev_enable", {31'd0, dev_enable}, 32'd0);
    check("R4 reset pulse", {31'd0, dev_reset_pulse}, 32'd0);

    // vector table: R1 R2 R3 R7 R9
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        bus_write(VECS[i].addr, VECS[i].val);
      end else begin
        bus_read(VECS[i].addr, rd);
        check($sformatf("R1/R3/R7/R9 vector %0d", i), rd, VECS[i].val);
      end
    end
    bus_read(6'h09, rd); check("R1 misaligned read", rd, 32'd0);

    // R8 enable follows bit 9
    bus_write(6'h00, 32'h0000_0200);
    check("R8 enable on", {31'd0, dev_enable}, 32'd1);
    bus_write(6'h00, 32'h0000_0000);
    check("R8 enable off", {31'd0, dev_enable}, 32'd0);
    bus_read(6'h00, rd); check("R7 zero write drain", rd, 32'hA400_0040);

    // R7 reset pulse
    bus_write(6'h00, 32'h0000_0080);
    check("R7 pulse high", {31'd0, dev_reset_pulse}, 32'd1);
    @(negedge clk);
    check("R7 pulse single", {31'd0, dev_reset_pulse}, 32'd0);
    bus_write(6'h00, 32'h0000_0040);
    check("R7 no pulse", {31'd0, dev_reset_pulse}, 32'd0);
    bus_read(6'h00, rd); check("R7 drain cleared", rd, 32'hA400_0000);

    // R5 masked pending, R6 unmask raises output
    dev_irq = 1'b1;
    @(negedge clk);
    check("R5 masked no irq", {31'd0, irq_out}, 32'd0);
    bus_read(6'h00, rd); check("R5 pending set", rd, 32'hA400_0001);
    bus_write(6'h00, 32'h0000_0010);
    check("R6 unmask raises irq", {31'd0, irq_out}, 32'd1);
    bus_read(6'h00, rd); check("R3 pending kept", rd, 32'hA400_0011);

    // R5 falling edge clears, R12 one cycle later
    dev_irq = 1'b0;
    #1 check("R12 irq still high", {31'd0, irq_out}, 32'd1);
    @(negedge clk);
    check("R5 fall clears irq", {31'd0, irq_out}, 32'd0);
    bus_read(6'h00, rd); check("R5 pending cleared", rd, 32'hA400_0010);

    dev_irq = 1'b1;
    #1 check("R12 irq still low", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R5 enabled rise", {31'd0, irq_out}, 32'd1);
    bus_write(6'h00, 32'h0000_0000);
    check("R6 mask drops irq", {31'd0, irq_out}, 32'd0);
    bus_read(6'h00, rd); check("R6 pending stays", rd, 32'hA400_0041);
    dev_irq = 1'b0;
    @(negedge clk);

    // R11 pointer advance and priority
    bus_write(6'h04, 32'h0000_0100);
    xfer_done = 1'b1; xfer_len = 16'h0020;
    @(negedge clk);
    xfer_done = 1'b0;
    bus_read(6'h04, rd); check("R11 single advance", rd, 32'h0000_0120);
    xfer_done = 1'b1; xfer_len = 16'h0004;
    @(negedge clk);
    xfer_len = 16'h0008;
    @(negedge clk);
    xfer_done = 1'b0;
    bus_read(6'h04, rd); check("R11 back to back", rd, 32'h0000_012C);
    xfer_done = 1'b1; xfer_len = 16'h0010;
    bus_write(6'h04, 32'h0000_0500);
    xfer_done = 1'b0;
    bus_read(6'h04, rd); check("R11 write priority", rd, 32'h0000_0500);

    // R10 wide window
    wide_mode = 1'b1;
    bus_write(6'h24, 32'hFFFF_FFFF);
    bus_write(6'h3C, 32'h1111_1111);
    bus_read(6'h04, rd); check("R10 high write ignored addr", rd, 32'h0000_0500);
    bus_read(6'h0C, rd); check("R10 high write ignored ext", rd, 32'hDEAD_0000);
    bus_read(6'h24, rd); check("R10 high read zero", rd, 32'd0);
    bus_read(6'h14, rd); check("R10 alias in window", rd, 32'h0000_0500);
    bus_write(6'h18, 32'h0000_ABCD);
    bus_read(6'h08, rd); check("R10 alias write", rd, 32'h0000_ABCD);

    done_flag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule